// File: doc/BRIEF.md
# Next-PC Branch and Jump Resolver

This block decides where a 32-bit processor fetches from next. Each cycle it takes the address of the current instruction, the instruction word, and the two register operands already read for its source fields. From these it chooses among straight-line flow, a conditional branch, a region-bounded absolute jump, a call that also records a return address, and a jump through a register. The decision is captured in an output register, so the result for the inputs present at one rising clock edge appears on the outputs just after that edge.

Straight-line flow advances by one 4-byte word. A branch that is taken moves by a signed word offset counted from the word after the current one. An absolute jump replaces the low 28 bits of that following address and keeps its top four bits, so it cannot leave its 256 MB region. A call does the same and also requests that the return address, eight bytes past the current one, be written into register 31. A register jump goes to the value of the first source operand. Instruction fetch, the register file, delay-slot handling and hazards are handled elsewhere.

Top module: `npc_resolver`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs become zero on that edge.
- R2: Any instruction that is not one of the recognised control transfers gives `next_pc_o` = pc+4 with `taken_o` low. This includes every opcode not listed below, opcode 0 with a function code other than 0x08, and opcode 1 with an rt field other than 0 or 1.
- R3: Opcode 0x2 (instruction bits 31:26) gives a target made of bits 31:28 of pc+4, then instruction bits 25:0, then two zero bits, with `taken_o` high.
- R4: Opcode 0x3 gives the same target as R3 with `taken_o` high, and raises `link_we_o` with `link_reg_o` = 31 and `link_val_o` = pc+8.
- R5: Opcode 0 with function code 0x08 (bits 5:0) gives `next_pc_o` = rs operand and `taken_o` high.
- R6: Opcode 0x4 is taken when the two operands are equal, and opcode 0x5 is taken when they differ. When such a branch is not taken, the result is pc+4.
- R7: Opcode 0x1 with rt field (bits 20:16) equal to 0 is taken when the rs operand is negative. With rt equal to 1 it is taken when the rs operand is zero or positive.
- R8: Opcode 0x6 is taken when the rs operand, read as signed, is at most zero. Opcode 0x7 is taken when it is above zero.
- R9: A taken branch goes to pc+4 plus the sign-extended 16-bit offset (bits 15:0) shifted left by two, wrapping modulo 2^32.
- R10: `link_we_o` is high only for opcode 0x3. When it is low, `link_reg_o` and `link_val_o` are zero.
- R11: A jump target always lies in the same 256 MB region as pc+4, including when pc+4 carries into the next region.
- R12: Outputs change only at a rising edge and reflect the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Operand read for the rs field |
| rt_val_i | input | 32 | Operand read for the rt field |
| next_pc_o | output | 32 | Resolved fetch address |
| taken_o | output | 1 | High when flow is redirected |
| link_we_o | output | 1 | Return-address write request |
| link_reg_o | output | 5 | Register index for the return address |
| link_val_o | output | 32 | Return address value |

## Verification
The block holds no state that outlives one cycle, so a wrong classification or a wrong target shows on `next_pc_o`, `taken_o` or the link outputs at the very next edge. Nothing is hidden that could surface later. Because of this, the comparisons look for boundary conditions that can mislead the decode. These are the sign of a zero or most-negative operand, the unused sub-opcode values, a negative offset that wraps below address zero, and a pc+4 that carries into the next region. A wrong link field would also show at once, even on an instruction that is not a call.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int INSN_W  = 32;
    localparam int OPC_W   = 6;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;
    localparam int JIDX_W  = 26;
    localparam int FUNC_W  = 6;

    localparam logic [OPC_W-1:0]  OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0]  OPC_REGIMM  = 6'h01;
    localparam logic [OPC_W-1:0]  OPC_JUMP    = 6'h02;
    localparam logic [OPC_W-1:0]  OPC_CALL    = 6'h03;
    localparam logic [OPC_W-1:0]  OPC_BEQ     = 6'h04;
    localparam logic [OPC_W-1:0]  OPC_BNE     = 6'h05;
    localparam logic [OPC_W-1:0]  OPC_BLEZ    = 6'h06;
    localparam logic [OPC_W-1:0]  OPC_BGTZ    = 6'h07;
    localparam logic [FUNC_W-1:0] FN_REGJUMP  = 6'h08;
    localparam logic [RIDX_W-1:0] SUB_LTZ     = 5'd0;
    localparam logic [RIDX_W-1:0] SUB_GEZ     = 5'd1;
    localparam logic [RIDX_W-1:0] LINK_IDX    = 5'd31;

    typedef enum logic [3:0] {
        FK_SEQ,
        FK_JUMP,
        FK_CALL,
        FK_REGJ,
        FK_EQ,
        FK_NE,
        FK_LTZ,
        FK_GEZ,
        FK_LEZ,
        FK_GTZ
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e          kind;
        logic [IMM_W-1:0]    offs;
        logic [JIDX_W-1:0]   jidx;
    } decoded_t;

    function automatic logic is_cond(input flow_kind_e k);
        return (k == FK_EQ) || (k == FK_NE) || (k == FK_LTZ) ||
               (k == FK_GEZ) || (k == FK_LEZ) || (k == FK_GTZ);
    endfunction

    function automatic logic is_uncond(input flow_kind_e k);
        return (k == FK_JUMP) || (k == FK_CALL) || (k == FK_REGJ);
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output decoded_t          dec
);
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] sub;
    logic [FUNC_W-1:0] fn;

    assign opc = instr[INSN_W-1 -: OPC_W];
    assign sub = instr[20:16];
    assign fn  = instr[FUNC_W-1:0];

    always_comb begin
        dec.offs = instr[IMM_W-1:0];
        dec.jidx = instr[JIDX_W-1:0];
        unique case (opc)
            OPC_SPECIAL: dec.kind = (fn == FN_REGJUMP) ? FK_REGJ : FK_SEQ;
            OPC_REGIMM: begin
                if (sub == SUB_LTZ)      dec.kind = FK_LTZ;
                else if (sub == SUB_GEZ) dec.kind = FK_GEZ;
                else                     dec.kind = FK_SEQ;
            end
            OPC_JUMP:    dec.kind = FK_JUMP;
            OPC_CALL:    dec.kind = FK_CALL;
            OPC_BEQ:     dec.kind = FK_EQ;
            OPC_BNE:     dec.kind = FK_NE;
            OPC_BLEZ:    dec.kind = FK_LEZ;
            OPC_BGTZ:    dec.kind = FK_GTZ;
            default:     dec.kind = FK_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  flow_kind_e       kind,
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    output logic             hit
);
    logic neg, zero, same;

    assign neg  = a_val[XLEN-1];
    assign zero = (a_val == '0);
    assign same = (a_val == b_val);

    always_comb begin
        unique case (kind)
            FK_EQ:   hit = same;
            FK_NE:   hit = !same;
            FK_LTZ:  hit = neg;
            FK_GEZ:  hit = !neg;
            FK_LEZ:  hit = neg || zero;
            FK_GTZ:  hit = !neg && !zero;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [IMM_W-1:0]  offs,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   jmp_pc,
    output logic [XLEN-1:0]   ret_pc
);
    localparam int REGION_W = XLEN - JIDX_W - 2;
    localparam int SEXT_W   = XLEN - IMM_W - 2;

    logic [XLEN-1:0] disp;

    assign seq_pc = pc + XLEN'(4);
    assign ret_pc = pc + XLEN'(8);
    assign disp   = {{SEXT_W{offs[IMM_W-1]}}, offs, 2'b00};
    assign br_pc  = seq_pc + disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_pc = {seq_pc[XLEN-1 -: REGION_W], jidx, 2'b00};
        end else begin : g_flat
            assign jmp_pc = {jidx, 2'b00};
        end
    endgenerate
endmodule

// File: rtl/npc_resolver.sv
module npc_resolver
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [INSN_W-1:0] instr_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              taken_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_reg_o,
    output logic [XLEN-1:0]   link_val_o
);
    localparam int REGION_W = XLEN - JIDX_W - 2;

    decoded_t         dec;
    logic             cond_hit;
    logic [XLEN-1:0]  seq_pc, br_pc, jmp_pc, ret_pc;
    logic [XLEN-1:0]  npc_d;
    logic             tk_d;
    logic             lnk_d;

    npc_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    npc_cond #(.XLEN(XLEN)) u_cond (
        .kind  (dec.kind),
        .a_val (rs_val_i),
        .b_val (rt_val_i),
        .hit   (cond_hit)
    );

    npc_target #(.XLEN(XLEN)) u_tgt (
        .pc     (pc_i),
        .offs   (dec.offs),
        .jidx   (dec.jidx),
        .seq_pc (seq_pc),
        .br_pc  (br_pc),
        .jmp_pc (jmp_pc),
        .ret_pc (ret_pc)
    );

    always_comb begin
        tk_d  = is_uncond(dec.kind) || (is_cond(dec.kind) && cond_hit);
        lnk_d = (dec.kind == FK_CALL);
        unique case (dec.kind)
            FK_JUMP, FK_CALL: npc_d = jmp_pc;
            FK_REGJ:          npc_d = rs_val_i;
            default:          npc_d = tk_d ? br_pc : seq_pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc_o  <= '0;
            taken_o    <= 1'b0;
            link_we_o  <= 1'b0;
            link_reg_o <= '0;
            link_val_o <= '0;
        end else begin
            next_pc_o  <= npc_d;
            taken_o    <= tk_d;
            link_we_o  <= lnk_d;
            link_reg_o <= lnk_d ? LINK_IDX : '0;
            link_val_o <= lnk_d ? ret_pc : '0;
        end
    end

    logic live_q;
    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b0;
        else     live_q <= 1'b1;
    end

    // R2
    seq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && !taken_o) |-> (next_pc_o == $past(pc_i) + XLEN'(4)));

    // R11
    region_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && (($past(instr_i[31:26]) == OPC_JUMP) || ($past(instr_i[31:26]) == OPC_CALL)))
        |-> (next_pc_o[XLEN-1 -: REGION_W] == $past(pc_i[XLEN-1 -: REGION_W] + REGION_W'(&pc_i[XLEN-REGION_W-1:2]))));

    // R10
    link_only_call_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && link_we_o) |-> (($past(instr_i[31:26]) == OPC_CALL) &&
                                   (link_reg_o == LINK_IDX) &&
                                   (link_val_o == $past(pc_i) + XLEN'(8))));

    // R4
    call_links_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && ($past(instr_i[31:26]) == OPC_CALL)) |-> (link_we_o && taken_o));

    // R5
    regjump_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && ($past(instr_i[31:26]) == OPC_SPECIAL) && ($past(instr_i[5:0]) == FN_REGJUMP))
        |-> (taken_o && (next_pc_o == $past(rs_val_i))));

    // R10
    link_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (live_q && !link_we_o) |-> (link_reg_o == '0 && link_val_o == '0));
endmodule

// File: tb/sim_npc_resolver.sv
module sim_npc_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o, link_we_o;
    logic [4:0]  link_reg_o;
    logic [31:0] link_val_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] lfsr = 32'hACE1_2468;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_resolver u0 (
        .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
        .next_pc_o(next_pc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_reg_o(link_reg_o), .link_val_o(link_val_o)
    );

    // Behavioural reference: what the requirements say, instruction by instruction.
    task automatic model(input logic [31:0] pc, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] e_pc, output logic e_tk,
                         output logic e_lw, output logic [4:0] e_lr,
                         output logic [31:0] e_lv, output string tag);
        int op;
        int sub;
        int fn;
        logic [31:0] after;
        logic [31:0] off;
        logic go;
        op    = int'(ins[31:26]);
        sub   = int'(ins[20:16]);
        fn    = int'(ins[5:0]);
        after = pc + 32'd4;
        off   = 32'($signed(ins[15:0])) * 32'd4;
        go    = 1'b0;
        e_pc  = after;
        e_tk  = 1'b0;
        e_lw  = 1'b0;
        e_lr  = 5'd0;
        e_lv  = 32'd0;
        tag   = "R2";
        if (op == 2 || op == 3) begin
            e_pc = (after & 32'hF000_0000) | (32'(ins[25:0]) << 2);
            e_tk = 1'b1;
            tag  = (op == 2) ? "R3" : "R4";
            if (op == 3) begin
                e_lw = 1'b1;
                e_lr = 5'd31;
                e_lv = pc + 32'd8;
            end
        end else if (op == 0 && fn == 8) begin
            e_pc = a;
            e_tk = 1'b1;
            tag  = "R5";
        end else if (op == 4 || op == 5) begin
            go  = (op == 4) ? (a == b) : (a != b);
            tag = "R6";
        end else if (op == 1 && (sub == 0 || sub == 1)) begin
            go  = (sub == 0) ? ($signed(a) < 0) : ($signed(a) >= 0);
            tag = "R7";
        end else if (op == 6 || op == 7) begin
            go  = (op == 6) ? ($signed(a) <= 0) : ($signed(a) > 0);
            tag = "R8";
        end
        if (go) begin
            e_pc = after + off;
            e_tk = 1'b1;
        end
    endtask

    task automatic step(input logic [31:0] pc, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input string note);
        logic [31:0] e_pc, e_lv;
        logic e_tk, e_lw;
        logic [4:0] e_lr;
        string tag;
        model(pc, ins, a, b, e_pc, e_tk, e_lw, e_lr, e_lv, tag);
        if (note != "") tag = note;
        pc_i = pc; instr_i = ins; rs_val_i = a; rt_val_i = b;
        @(posedge clk);
        @(negedge clk);
        total++;
        if (next_pc_o !== e_pc || taken_o !== e_tk) begin
            bad++;
            $display("FAIL %s (R12 timing): next_pc=%h taken=%b expected next_pc=%h taken=%b ins=%h",
                     tag, next_pc_o, taken_o, e_pc, e_tk, ins);
        end
        total++;
        if (link_we_o !== e_lw || link_reg_o !== e_lr || link_val_o !== e_lv) begin
            bad++;
            $display("FAIL R10: link we=%b reg=%0d val=%h expected we=%b reg=%0d val=%h ins=%h",
                     link_we_o, link_reg_o, link_val_o, e_lw, e_lr, e_lv, ins);
        end
    endtask

    task automatic check_reset();
        rst = 1'b1;
        pc_i = 32'h1234_5678; instr_i = {6'h02, 26'h3FF_FFFF};
        @(posedge clk);
        @(negedge clk);
        total++;
        if (next_pc_o !== 32'd0 || taken_o !== 1'b0 || link_we_o !== 1'b0 ||
            link_reg_o !== 5'd0 || link_val_o !== 32'd0) begin
            bad++;
            $display("FAIL R1: pc=%h tk=%b lw=%b lr=%0d lv=%h expected all zero",
                     next_pc_o, taken_o, link_we_o, link_reg_o, link_val_o);
        end
        rst = 1'b0;
    endtask

    function automatic logic [31:0] ins_i(input int op, input int rs, input int rt, input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        check_reset();
        // R2 plain flow and unknown encodings
        step(32'h0040_0000, 32'h2108_0004, 32'd1, 32'd2, "R2");
        step(32'h0040_0004, {6'h00, 20'h0, 6'h20}, 32'h5, 32'h5, "R2");
        step(32'h0040_0008, ins_i(1, 3, 2, 16'h0010), 32'hFFFF_FFFF, 0, "R2");
        step(32'h0040_000C, ins_i(1, 3, 31, 16'h0010), 32'd0, 0, "R2");
        step(32'h0040_0010, ins_i(6'h23, 4, 5, 16'h0004), 0, 0, "R2");
        // R3 jump, R11 region carry at the top of a region
        step(32'h0040_0000, {6'h02, 26'h284_8603}, 0, 0, "R3");
        step(32'h2FFF_FFFC, {6'h02, 26'h000_0010}, 0, 0, "R11");
        step(32'hFFFF_FFFC, {6'h02, 26'h3FF_FFFF}, 0, 0, "R11");
        // R4 call with link
        step(32'h1000_0100, {6'h03, 26'h012_1808}, 0, 0, "R4");
        step(32'h7FFF_FFF8, {6'h03, 26'h000_0001}, 0, 0, "R4");
        // R5 register jump
        step(32'h0000_0200, {6'h00, 5'd3, 15'd0, 6'h08}, 32'hABCD_1234, 0, "R5");
        // R6 equality branches
        step(32'h0000_1000, ins_i(4, 5, 1, 16'h0003), 32'd7, 32'd7, "R6");
        step(32'h0000_1000, ins_i(4, 5, 1, 16'h0003), 32'd7, 32'd8, "R6");
        step(32'h0000_1000, ins_i(5, 5, 1, 16'hFFFE), 32'd7, 32'd8, "R6");
        step(32'h0000_1000, ins_i(5, 5, 1, 16'hFFFE), 32'd9, 32'd9, "R6");
        // R7 sign tests through the sub-opcode
        step(32'h0000_2000, ins_i(1, 5, 0, 16'h0002), 32'h8000_0000, 0, "R7");
        step(32'h0000_2000, ins_i(1, 5, 0, 16'h0002), 32'd0, 0, "R7");
        step(32'h0000_2000, ins_i(1, 5, 1, 16'h0002), 32'd0, 0, "R7");
        step(32'h0000_2000, ins_i(1, 5, 1, 16'h0002), 32'hFFFF_FFFF, 0, "R7");
        // R8 signed compare with zero
        step(32'h0000_3000, ins_i(6, 5, 0, 16'h0010), 32'd0, 0, "R8");
        step(32'h0000_3000, ins_i(6, 5, 0, 16'h0010), 32'd1, 0, "R8");
        step(32'h0000_3000, ins_i(7, 5, 0, 16'h0010), 32'h7FFF_FFFF, 0, "R8");
        step(32'h0000_3000, ins_i(7, 5, 0, 16'h0010), 32'h8000_0000, 0, "R8");
        step(32'h0000_3000, ins_i(7, 5, 0, 16'h0010), 32'd0, 0, "R8");
        // R9 offset extremes and wraparound below zero
        step(32'h0000_0000, ins_i(4, 0, 0, 16'hFFFE), 0, 0, "R9");
        step(32'h0001_0000, ins_i(4, 0, 0, 16'h8000), 0, 0, "R9");
        step(32'hFFFF_FFF8, ins_i(4, 0, 0, 16'h7FFF), 0, 0, "R9");
        // R1 reset again in mid-run
        step(32'h1000_0100, {6'h03, 26'h000_0040}, 0, 0, "R4");
        check_reset();
        // Mixed stream, every cycle compared against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w, a, b, pc;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = lfsr * 32'h9E37_79B9;
            pc = {w[31:2], 2'b00} ^ 32'h0F0F_0000;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = (lfsr[3:0] == 0) ? 32'd0 : lfsr * 32'h85EB_CA6B;
            b = lfsr[4] ? a : ~a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            w = lfsr * 32'hC2B2_AE35;
            if (w[31]) w[31:26] = {3'b000, w[28:26]};
            if (w[31:26] == 6'h00 && w[7]) w[5:0] = 6'h08;
            if (w[31:26] == 6'h01 && w[6]) w[20:16] = {4'b0, w[16]};
            step(pc, w, a, b, "");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule